// File: doc/BRIEF.md
# Pulse-Driven Output Latch Receiver with Starvation Default

This block sits on the output side of a pulse-coded isolation link. Each channel receives single-cycle "set" and "clear" pulses that were decoded from the barrier. A per-channel bistable latch turns those pulses back into a steady logic level, and that level is held between pulses.

A per-channel starvation watchdog counts the clock cycles since the last pulse of either kind. When traffic stops for longer than a programmed number of cycles, the channel is treated as having lost its input side. Its output then switches to a default level chosen by a single control input. The first pulse that arrives afterwards returns the channel to normal data.

Two status inputs from the output supply domain override everything else. When supply is absent, the drivers are disabled (high impedance). During the low-voltage bias window, the outputs are actively driven low.

Top module: `iso_rx_decoder`

## Requirements
- R1: A cycle with `set_pulse[i]=1` and `clr_pulse[i]=0` makes the latch of channel i hold 1 from the next clock edge. With supply good, no low bias and the channel not starved, `data_out[i]` is then 1.
- R2: A cycle with `clr_pulse[i]=1` and `set_pulse[i]=0` makes the latch hold 0 from the next edge. The latch keeps its value through cycles with no pulse.
- R3: A cycle with both pulses high on channel i leaves that latch unchanged and sets `pulse_conflict[i]` to 1. That flag stays 1 until reset.
- R4: After TIMEOUT_CYC consecutive edges with no pulse on channel i, the channel is starved. After TIMEOUT_CYC-1 such edges it is not yet starved.
- R5: A starved channel with supply good and no low bias drives `dflt_sel`: 1 gives high, 0 gives low. A board pull-up on `dflt_sel` makes an unconnected control read as high.
- R6: `dflt_sel` has no effect on a channel that is not starved.
- R7: Any pulse on a starved channel clears starvation at the next edge, so the output follows the latch one cycle after that pulse.
- R8: While `out_pwr_ok=0`, every `drive_en` bit is 0 (high impedance) and `data_out` is all zeros.
- R9: While `out_pwr_ok=1` and `low_bias=1`, every `drive_en` bit is 1 and `data_out` is all zeros, whatever the latch or default.
- R10: Synchronous reset puts every channel in the starved state with latch 0 and conflict flag 0.
- R11: Channels are independent: pulses on one channel never change the latch, watchdog or flag of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | NCH | Per-channel set pulses, one cycle each |
| clr_pulse | input | NCH | Per-channel clear pulses, one cycle each |
| dflt_sel | input | 1 | Default level for starved channels |
| out_pwr_ok | input | 1 | Output-side supply present |
| low_bias | input | 1 | Output supply in its low-voltage window, force low |
| data_out | output | NCH | Per-channel output level |
| drive_en | output | NCH | Per-channel driver enable (0 = high impedance) |
| pulse_conflict | output | NCH | Sticky per-channel set/clear collision flag |

## Verification
The bench builds the block with three channels and TIMEOUT_CYC set to 40. This brings the exact starvation boundary within a few dozen cycles, so directed tests can hit the edge before it and the edge at it. It also lets random phases with sparse pulse rates starve and revive channels many times during a run. Three channels are enough to show that a collision or starvation on one channel leaves its neighbours unchanged.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

    typedef enum logic [1:0] {
        DRV_OFF      = 2'd0,
        DRV_BIAS_LOW = 2'd1,
        DRV_DEFAULT  = 2'd2,
        DRV_DATA     = 2'd3
    } drv_mode_e;

    typedef struct packed {
        logic lvl;
        logic conflict;
    } latch_state_t;

    // Priority: missing supply, then low-bias window, then starvation, then data
    function automatic drv_mode_e pick_mode(input logic pwr_ok,
                                            input logic bias_low,
                                            input logic starved);
        drv_mode_e m;
        if (!pwr_ok)       m = DRV_OFF;
        else if (bias_low) m = DRV_BIAS_LOW;
        else if (starved)  m = DRV_DEFAULT;
        else               m = DRV_DATA;
        return m;
    endfunction

    function automatic logic mode_level(input drv_mode_e m,
                                        input logic lvl,
                                        input logic dflt);
        logic r;
        case (m)
            DRV_DATA:    r = lvl;
            DRV_DEFAULT: r = dflt;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rx_latch.sv
module rx_latch
    import iso_rx_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         set_i,
    input  logic         clr_i,
    output latch_state_t st_o
);
    latch_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (set_i && clr_i)      st_q.conflict <= 1'b1;
            if (set_i && !clr_i)     st_q.lvl      <= 1'b1;
            else if (clr_i && !set_i) st_q.lvl     <= 1'b0;
        end
    end

    assign st_o = st_q;

    assert_set_R1: assert property (@(posedge clk) disable iff (rst)
        (set_i && !clr_i) |=> st_q.lvl);
    assert_clr_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !st_q.lvl);
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(st_q.lvl));
    assert_both_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (set_i && clr_i) |=> ($stable(st_q.lvl) && st_q.conflict));
    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        st_q.conflict |=> st_q.conflict);
endmodule

// File: rtl/rx_watchdog.sv
module rx_watchdog #(
    parameter int TIMEOUT_CYC = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_i,
    output logic starved_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

    logic [CW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst)              idle_q <= LIMIT;
        else if (pulse_i)     idle_q <= '0;
        else if (idle_q != LIMIT) idle_q <= idle_q + 1'b1;
    end

    assign starved_o = (idle_q == LIMIT);

    assert_revive_R7: assert property (@(posedge clk) disable iff (rst)
        pulse_i |=> !starved_o);
    assert_stay_starved_R4: assert property (@(posedge clk) disable iff (rst)
        (starved_o && !pulse_i) |=> starved_o);
    assert_count_up_R4: assert property (@(posedge clk) disable iff (rst)
        (!starved_o && !pulse_i) |=> (idle_q == $past(idle_q) + 1'b1));
endmodule

// File: rtl/rx_drive.sv
module rx_drive
    import iso_rx_pkg::*;
(
    input  logic pwr_ok,
    input  logic bias_low,
    input  logic starved,
    input  logic lvl,
    input  logic dflt,
    output logic data_o,
    output logic en_o
);
    drv_mode_e mode;

    always_comb begin
        mode   = pick_mode(pwr_ok, bias_low, starved);
        data_o = mode_level(mode, lvl, dflt);
        en_o   = (mode != DRV_OFF);
    end
endmodule

// File: rtl/iso_rx_decoder.sv
module iso_rx_decoder
    import iso_rx_pkg::*;
#(
    parameter int NCH         = 3,
    parameter int TIMEOUT_CYC = 500
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_pulse,
    input  logic [NCH-1:0] clr_pulse,
    input  logic           dflt_sel,
    input  logic           out_pwr_ok,
    input  logic           low_bias,
    output logic [NCH-1:0] data_out,
    output logic [NCH-1:0] drive_en,
    output logic [NCH-1:0] pulse_conflict
);
    latch_state_t   st     [NCH];
    logic [NCH-1:0] starved;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        rx_latch u_latch (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_pulse[i]),
            .clr_i (clr_pulse[i]),
            .st_o  (st[i])
        );

        rx_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
            .clk       (clk),
            .rst       (rst),
            .pulse_i   (set_pulse[i] | clr_pulse[i]),
            .starved_o (starved[i])
        );

        rx_drive u_drv (
            .pwr_ok   (out_pwr_ok),
            .bias_low (low_bias),
            .starved  (starved[i]),
            .lvl      (st[i].lvl),
            .dflt     (dflt_sel),
            .data_o   (data_out[i]),
            .en_o     (drive_en[i])
        );

        assign pulse_conflict[i] = st[i].conflict;

        assert_data_path_R6: assert property (@(posedge clk) disable iff (rst)
            (out_pwr_ok && !low_bias && !starved[i]) |-> (data_out[i] == st[i].lvl));
        assert_default_path_R5: assert property (@(posedge clk) disable iff (rst)
            (out_pwr_ok && !low_bias && starved[i]) |-> (data_out[i] == dflt_sel));
    end

    assert_hiz_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !out_pwr_ok |-> (drive_en == '0 && data_out == '0));
    assert_bias_low_R9: assert property (@(posedge clk) disable iff (rst)
        (out_pwr_ok && low_bias) |-> (data_out == '0 && drive_en == '1));
endmodule

// File: tb/tb_iso_rx_decoder.sv
module tb_iso_rx_decoder;
    localparam int NCH = 3;
    localparam int TO  = 40;

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] set_pulse, clr_pulse;
    logic           dflt_sel, out_pwr_ok, low_bias;
    logic [NCH-1:0] data_out, drive_en, pulse_conflict;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // reference model
    logic [NCH-1:0] m_lvl, m_err;
    int             m_idle [NCH];

    iso_rx_decoder #(.NCH(NCH), .TIMEOUT_CYC(TO)) dut (
        .clk(clk), .rst(rst), .set_pulse(set_pulse), .clr_pulse(clr_pulse),
        .dflt_sel(dflt_sel), .out_pwr_ok(out_pwr_ok), .low_bias(low_bias),
        .data_out(data_out), .drive_en(drive_en), .pulse_conflict(pulse_conflict)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual=hung expected=finished");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    function automatic logic [NCH-1:0] exp_data();
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) begin
            if (!out_pwr_ok || low_bias) r[i] = 1'b0;
            else if (m_idle[i] >= TO)    r[i] = dflt_sel;
            else                         r[i] = m_lvl[i];
        end
        return r;
    endfunction

    function automatic logic [NCH-1:0] exp_en();
        return out_pwr_ok ? '1 : '0;
    endfunction

    task automatic model_edge();
        for (int i = 0; i < NCH; i++) begin
            if (set_pulse[i] && clr_pulse[i]) m_err[i] = 1'b1;
            else if (set_pulse[i])            m_lvl[i] = 1'b1;
            else if (clr_pulse[i])            m_lvl[i] = 1'b0;
            if (set_pulse[i] || clr_pulse[i]) m_idle[i] = 0;
            else if (m_idle[i] < TO)          m_idle[i]++;
        end
    endtask

    task automatic compare(input string tag);
        logic [NCH-1:0] ed, ee;
        ed = exp_data();
        ee = exp_en();
        checks++;
        if (data_out !== ed || drive_en !== ee || pulse_conflict !== m_err) begin
            errors++;
            $display("FAIL %s: actual data=%b en=%b err=%b expected data=%b en=%b err=%b",
                     tag, data_out, drive_en, pulse_conflict, ed, ee, m_err);
        end
    endtask

    task automatic step(input logic [NCH-1:0] s, input logic [NCH-1:0] c,
                        input logic d, input logic p, input logic lb,
                        input string tag);
        @(negedge clk);
        set_pulse = s; clr_pulse = c;
        dflt_sel = d; out_pwr_ok = p; low_bias = lb;
        @(posedge clk);
        model_edge();
        #1;
        compare(tag);
    endtask

    task automatic idle(input int n, input logic d, input string tag);
        for (int k = 0; k < n; k++) step('0, '0, d, 1'b1, 1'b0, tag);
    endtask

    initial begin
        set_pulse = '0; clr_pulse = '0;
        dflt_sel = 1'b1; out_pwr_ok = 1'b1; low_bias = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_lvl = '0; m_err = '0;
        for (int i = 0; i < NCH; i++) m_idle[i] = TO;
        #1;
        compare("R10 reset state, default high");
        step('0, '0, 1'b0, 1'b1, 1'b0, "R10 starved after reset, default low");

        // R1/R7: first set pulse revives channel 0 only (R11)
        step(3'b001, '0, 1'b0, 1'b1, 1'b0, "R1 R7 set revives ch0");
        // R6: dflt_sel flips with ch0 live
        step('0, '0, 1'b1, 1'b1, 1'b0, "R6 default ignored while live");
        step('0, 3'b001, 1'b1, 1'b1, 1'b0, "R2 clear ch0");
        idle(3, 1'b1, "R2 hold between pulses / R6");
        step(3'b001, '0, 1'b0, 1'b1, 1'b0, "R1 set ch0 again");
        // R4 boundary: TO-1 idle edges -> still data; one more -> default
        idle(TO - 1, 1'b0, "R4 not yet starved");
        step('0, '0, 1'b0, 1'b1, 1'b0, "R4 R5 starved to default low");
        step('0, '0, 1'b1, 1'b1, 1'b0, "R5 default follows control high");
        step('0, 3'b001, 1'b1, 1'b1, 1'b0, "R7 clear pulse revives ch0");

        // R3 collision on ch1
        step(3'b010, '0, 1'b0, 1'b1, 1'b0, "R1 set ch1");
        step(3'b010, 3'b010, 1'b0, 1'b1, 1'b0, "R3 collision holds, flag set");
        step('0, 3'b010, 1'b0, 1'b1, 1'b0, "R3 flag sticky after clear");
        step(3'b100, 3'b100, 1'b0, 1'b1, 1'b0, "R3 R11 collision on ch2 only");

        // R8/R9 supply overrides
        step(3'b011, '0, 1'b1, 1'b0, 1'b0, "R8 no supply hi-z");
        step('0, '0, 1'b1, 1'b1, 1'b1, "R9 low bias forces low");
        step('0, '0, 1'b1, 1'b0, 1'b1, "R8 supply loss beats low bias");
        step('0, '0, 1'b1, 1'b1, 1'b0, "R1 data after overrides");

        // random phases with varying pulse density
        for (int ph = 0; ph < 8; ph++) begin
            int dens;
            dens = (ph % 2 == 0) ? 4 : 200;
            for (int k = 0; k < 400; k++) begin
                logic [NCH-1:0] s, c;
                logic d, p, lb;
                for (int i = 0; i < NCH; i++) begin
                    s[i] = ($urandom % dens) == 0;
                    c[i] = ($urandom % dens) == 0;
                end
                d  = $urandom % 2;
                p  = ($urandom % 20) != 0;
                lb = ($urandom % 25) == 0;
                step(s, c, d, p, lb, "R11 random traffic");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
    end
endmodule